// File: doc/BRIEF.md
# Quick-Pulse Programming Sequencer

This block drives the program strobe for one non-volatile memory location. A start request carries the location address, the byte to write and a target selector: the code array, the encryption table or the security bits. The block then produces a fixed burst of active-low program pulses. Each pulse lasts a programmed number of time-base ticks and is followed by a programmed gap. When the last gap ends, the block reports completion.

The pulse width and the gap length are held in two count registers. A command decoder loads them. They are measured in ticks of a clock-enable input, so the real durations (for example a 50 µs pulse and a 10 µs gap) follow from the tick rate. The address, data and target are captured at start. They are presented on the outputs, unchanged, for the whole burst.

Top module: `qpp_sequencer`

## Requirements
- R1: An accepted start produces exactly NPULSE (default 25) low pulses on `prog_n`. `prog_n` is driven low only during a pulse.
- R2: Each pulse stays low for exactly the width count, counted in cycles where `tick` is high. The width count is the value in the width register when the burst starts.
- R3: Every pulse, the last one included, is followed by a high gap. The gap lasts exactly the gap count in `tick` cycles, and then the next pulse or completion follows.
- R4: A width or gap count of zero behaves as a count of one.
- R5: `busy` rises in the cycle after the start is accepted. It stays high until completion. Whenever `busy` is low, `prog_n` is high.
- R6: `done` is high for exactly one cycle. That is the cycle after the final gap's last tick, and the first cycle in which `busy` is low again.
- R7: `pgm_addr`, `pgm_data` and `pgm_target` take the start inputs' values at the accepted start and hold them through the burst, whatever those inputs do later. Target codes are 0 for code array, 1 for encryption table, 2 for security bits and 3 reserved. All four codes are sequenced identically.
- R8: A start request while `busy` is high is ignored. The running burst keeps its location, its pulse count and its timing. No second burst follows it.
- R9: `cfg_load` writes `cfg_width` and `cfg_gap` into the count registers on the next edge. After reset they hold RST_WIDTH (default 50) and RST_GAP (default 10). A load during a burst affects only later bursts.
- R10: After reset the block is idle: `busy` is low, `done` is low, `prog_n` is high and the location outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base clock enable for pulse and gap timing |
| cfg_load | input | 1 | Load strobe for the count registers |
| cfg_width | input | 8 | New pulse width count in ticks |
| cfg_gap | input | 8 | New gap count in ticks |
| start | input | 1 | Request to program one location |
| start_addr | input | 13 | Location address |
| start_data | input | 8 | Byte to program |
| start_target | input | 2 | Target selector (0 code, 1 encryption, 2 security) |
| busy | output | 1 | Burst in progress |
| prog_n | output | 1 | Active-low program strobe |
| done | output | 1 | One-cycle completion pulse |
| pgm_addr | output | 13 | Latched address |
| pgm_data | output | 8 | Latched data |
| pgm_target | output | 2 | Latched target |

## Verification
The bench counts ticks, not cycles, inside every low and high run. It also uses a sparse tick. A design that timed pulses in raw clocks, or counted ticks outside its own phase, would then show wrong run lengths. Zero counts and the maximum count check that a zero does not become a zero-width pulse or a 256-tick wrap. The bench injects a start and a register load in the middle of a burst and then changes the start inputs. A design that re-latched or re-read its settings would alter the location, the pulse count or the timing of the running burst, or would begin a second burst. The bench checks the final gap and the single `done` cycle, which catches a design that ends on the last pulse or holds `done` for more than one cycle.

// File: rtl/qpp_pkg.sv
package qpp_pkg;

    localparam int ADDR_W = 13;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 8;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        TGT_CODE   = 2'd0,
        TGT_CRYPT  = 2'd1,
        TGT_SECURE = 2'd2,
        TGT_RSVD   = 2'd3
    } target_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        target_e           target;
    } loc_t;

    typedef struct packed {
        cnt_t width;
        cnt_t gap;
    } timing_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_GAP   = 2'd2
    } phase_e;

    // A zero count is stretched to one tick.
    function automatic cnt_t eff_count(input cnt_t c);
        return (c == '0) ? cnt_t'(1) : c;
    endfunction

endpackage

// File: rtl/qpp_timing_regs.sv
module qpp_timing_regs
    import qpp_pkg::*;
#(
    parameter int RST_WIDTH = 50,
    parameter int RST_GAP   = 10
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  cnt_t    width_in,
    input  cnt_t    gap_in,
    output timing_t cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.width <= cnt_t'(RST_WIDTH);
            cfg.gap   <= cnt_t'(RST_GAP);
        end else if (load) begin
            cfg.width <= width_in;
            cfg.gap   <= gap_in;
        end
    end

endmodule

// File: rtl/qpp_tick_timer.sv
module qpp_tick_timer
    import qpp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  cnt_t load_val,
    input  logic tick,
    output logic last
);

    cnt_t cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (tick && cnt != '0) begin
            cnt <= cnt - cnt_t'(1);
        end
    end

    // The next tick ends the current interval.
    assign last = (cnt == cnt_t'(1));

    // R4: every interval is loaded with a nonzero length
    a_r4_load_nonzero: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt != '0));

endmodule

// File: rtl/qpp_burst_ctrl.sv
module qpp_burst_ctrl
    import qpp_pkg::*;
#(
    parameter int NPULSE = 25
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    tick,
    input  logic    start,
    input  loc_t    loc_in,
    input  timing_t cfg,
    input  logic    timer_last,
    output logic    timer_load,
    output cnt_t    timer_val,
    output logic    busy,
    output logic    prog_n,
    output logic    done,
    output loc_t    loc_q
);

    localparam int IDX_W = (NPULSE > 1) ? $clog2(NPULSE) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NPULSE - 1);

    phase_e            phase, nxt;
    logic [IDX_W-1:0]  pulse_idx;
    timing_t           timing_q;
    logic              last_pulse;
    logic              fire_done;
    logic              accept;
    logic              advance;

    assign last_pulse = (pulse_idx == IDX_LAST);
    assign accept     = (phase == ST_IDLE) && start;
    assign advance    = (phase == ST_GAP) && tick && timer_last && !last_pulse;

    always_comb begin
        nxt        = phase;
        timer_load = 1'b0;
        timer_val  = eff_count(timing_q.width);
        fire_done  = 1'b0;
        unique case (phase)
            ST_IDLE: begin
                if (start) begin
                    nxt        = ST_PULSE;
                    timer_load = 1'b1;
                    timer_val  = eff_count(cfg.width);
                end
            end
            ST_PULSE: begin
                if (tick && timer_last) begin
                    nxt        = ST_GAP;
                    timer_load = 1'b1;
                    timer_val  = eff_count(timing_q.gap);
                end
            end
            ST_GAP: begin
                if (tick && timer_last) begin
                    if (last_pulse) begin
                        nxt       = ST_IDLE;
                        fire_done = 1'b1;
                    end else begin
                        nxt        = ST_PULSE;
                        timer_load = 1'b1;
                    end
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= ST_IDLE;
            pulse_idx <= '0;
            timing_q  <= '0;
            loc_q     <= '0;
            busy      <= 1'b0;
            prog_n    <= 1'b1;
            done      <= 1'b0;
        end else begin
            phase  <= nxt;
            busy   <= (nxt != ST_IDLE);
            prog_n <= (nxt != ST_PULSE);
            done   <= fire_done;
            if (accept) begin
                loc_q     <= loc_in;
                timing_q  <= cfg;
                pulse_idx <= '0;
            end else if (advance) begin
                pulse_idx <= pulse_idx + 1'b1;
            end
        end
    end

    // R1: pulse index never runs past the burst length
    a_r1_idx_range: assert property (@(posedge clk) disable iff (rst)
        pulse_idx <= IDX_LAST);

    // R5: strobe inactive whenever idle
    a_r5_idle_strobe_high: assert property (@(posedge clk) disable iff (rst)
        !busy |-> prog_n);

    // R6: completion is a single cycle and coincides with busy falling
    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r6_done_on_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R7: latched location constant while busy
    a_r7_loc_hold: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy || $stable(loc_q)));

    // R8: a start while busy does not restart the pulse count
    a_r8_no_restart: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (pulse_idx >= $past(pulse_idx)));

endmodule

// File: rtl/qpp_sequencer.sv
module qpp_sequencer
    import qpp_pkg::*;
#(
    parameter int NPULSE    = 25,
    parameter int RST_WIDTH = 50,
    parameter int RST_GAP   = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              cfg_load,
    input  logic [CNT_W-1:0]  cfg_width,
    input  logic [CNT_W-1:0]  cfg_gap,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [DATA_W-1:0] start_data,
    input  logic [1:0]        start_target,
    output logic              busy,
    output logic              prog_n,
    output logic              done,
    output logic [ADDR_W-1:0] pgm_addr,
    output logic [DATA_W-1:0] pgm_data,
    output logic [1:0]        pgm_target
);

    timing_t cfg;
    loc_t    loc_in;
    loc_t    loc_q;
    logic    timer_load;
    cnt_t    timer_val;
    logic    timer_last;

    assign loc_in.addr   = start_addr;
    assign loc_in.data   = start_data;
    assign loc_in.target = target_e'(start_target);

    qpp_timing_regs #(
        .RST_WIDTH (RST_WIDTH),
        .RST_GAP   (RST_GAP)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .load     (cfg_load),
        .width_in (cfg_width),
        .gap_in   (cfg_gap),
        .cfg      (cfg)
    );

    qpp_tick_timer u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (timer_load),
        .load_val (timer_val),
        .tick     (tick),
        .last     (timer_last)
    );

    qpp_burst_ctrl #(
        .NPULSE (NPULSE)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .start      (start),
        .loc_in     (loc_in),
        .cfg        (cfg),
        .timer_last (timer_last),
        .timer_load (timer_load),
        .timer_val  (timer_val),
        .busy       (busy),
        .prog_n     (prog_n),
        .done       (done),
        .loc_q      (loc_q)
    );

    assign pgm_addr   = loc_q.addr;
    assign pgm_data   = loc_q.data;
    assign pgm_target = loc_q.target;

endmodule

// File: tb/qpp_sequencer_tb.sv
module qpp_sequencer_tb;

    localparam int NP = 25;

    logic        clk = 1'b0;
    logic        rst;
    logic        tick;
    logic        cfg_load;
    logic [7:0]  cfg_width;
    logic [7:0]  cfg_gap;
    logic        start;
    logic [12:0] start_addr;
    logic [7:0]  start_data;
    logic [1:0]  start_target;
    logic        busy;
    logic        prog_n;
    logic        done;
    logic [12:0] pgm_addr;
    logic [7:0]  pgm_data;
    logic [1:0]  pgm_target;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    qpp_sequencer u_dut (
        .clk(clk), .rst(rst), .tick(tick), .cfg_load(cfg_load),
        .cfg_width(cfg_width), .cfg_gap(cfg_gap), .start(start),
        .start_addr(start_addr), .start_data(start_data),
        .start_target(start_target), .busy(busy), .prog_n(prog_n),
        .done(done), .pgm_addr(pgm_addr), .pgm_data(pgm_data),
        .pgm_target(pgm_target)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic load_counts(input int w, input int g);
        @(negedge clk);
        cfg_load  = 1'b1;
        cfg_width = 8'(w);
        cfg_gap   = 8'(g);
        @(negedge clk);
        cfg_load  = 1'b0;
    endtask

    // One burst, measured in ticks per run. w and g are effective counts.
    // inject_at: cycle for a start while busy; cfg_at: cycle for a mid-burst load.
    task automatic run_burst(input string tag, input logic [12:0] a,
                             input logic [7:0] d, input logic [1:0] t,
                             input int w, input int g, input int period,
                             input int inject_at, input int cfg_at,
                             input int nw, input int ng);
        int  cyc = 0, pulses = 0, low = 0, high = 0;
        int  low_bad = -1, gap_bad = -1;
        bit  prev_low = 1'b0, hold_ok = 1'b1, busy_ok = 1'b1, early_done = 1'b0;
        @(negedge clk);
        tick = 1'b0; start = 1'b1;
        start_addr = a; start_data = d; start_target = t;
        @(negedge clk);
        start = 1'b0;
        start_addr = ~a; start_data = ~d; start_target = ~t;
        while (!done && cyc < 20000) begin
            if (!busy) busy_ok = 1'b0;
            if (pgm_addr != a || pgm_data != d || pgm_target != t) hold_ok = 1'b0;
            if (!prog_n && !prev_low) begin
                if (pulses > 0 && high != g && gap_bad < 0) gap_bad = high;
                pulses++;
                low = 0;
            end else if (prog_n && prev_low) begin
                if (low != w && low_bad < 0) low_bad = low;
                high = 0;
            end
            tick = ((cyc % period) == period - 1);
            if (tick) begin
                if (!prog_n) low++;
                else high++;
            end
            start = (cyc == inject_at);
            if (cyc == inject_at) begin
                start_addr = a ^ 13'h1; start_data = d ^ 8'h1; start_target = t ^ 2'h1;
            end
            cfg_load = (cyc == cfg_at);
            if (cyc == cfg_at) begin
                cfg_width = 8'(nw); cfg_gap = 8'(ng);
            end
            prev_low = !prog_n;
            cyc++;
            @(negedge clk);
            if (done && busy) early_done = 1'b1;
        end
        tick = 1'b0; start = 1'b0; cfg_load = 1'b0;
        check(done === 1'b1, "R6", {tag, " done reached"}, done, 1);
        check(pulses == NP, "R1", {tag, " pulse count"}, pulses, NP);
        check(low_bad < 0, "R2", {tag, " pulse width ticks"}, low_bad, w);
        check(!prev_low && high == g && gap_bad < 0, "R3",
              {tag, " gap ticks"}, (gap_bad < 0) ? high : gap_bad, g);
        check(busy_ok, "R5", {tag, " busy held"}, busy_ok, 1);
        check(!busy && prog_n && !early_done, "R6", {tag, " busy low at done"}, busy, 0);
        check(hold_ok, "R7", {tag, " location held"}, pgm_addr, a);
        @(negedge clk);
        check(!done, "R6", {tag, " done one cycle"}, done, 0);
        check(!busy && prog_n, "R8", {tag, " no second burst"}, busy, 0);
        check(pgm_addr == a && pgm_data == d && pgm_target == t, "R7",
              {tag, " outputs after done"}, pgm_data, d);
    endtask

    task automatic t_reset;
        check(!busy && !done && prog_n, "R10", "reset idle", {busy, done, prog_n}, 3'b001);
        check(pgm_addr == '0 && pgm_data == '0 && pgm_target == '0, "R10",
              "reset location", pgm_addr, 0);
    endtask

    task automatic t_reset_counts;   // R9 defaults 50 / 10
        run_burst("reset counts", 13'h0123, 8'hA5, 2'd0, 50, 10, 1, -1, -1, 0, 0);
    endtask

    task automatic t_fast;           // R2 R3 tick every cycle
        load_counts(3, 2);
        run_burst("fast", 13'h1FFF, 8'h3C, 2'd0, 3, 2, 1, -1, -1, 0, 0);
    endtask

    task automatic t_slow_tick;      // R2 R3 sparse tick, encryption target
        load_counts(4, 3);
        run_burst("slow tick", 13'h0001, 8'hFF, 2'd1, 4, 3, 3, -1, -1, 0, 0);
    endtask

    task automatic t_zero_counts;    // R4
        load_counts(0, 0);
        run_burst("zero counts", 13'h0AAA, 8'h00, 2'd2, 1, 1, 2, -1, -1, 0, 0);
    endtask

    task automatic t_start_busy;     // R8
        load_counts(2, 2);
        run_burst("start busy", 13'h0555, 8'h5A, 2'd2, 2, 2, 1, 20, -1, 0, 0);
    endtask

    task automatic t_cfg_midburst;   // R9 load during burst applies later
        load_counts(3, 2);
        run_burst("cfg mid", 13'h0100, 8'h81, 2'd3, 3, 2, 1, -1, 10, 6, 1);
        run_burst("cfg next", 13'h0200, 8'h18, 2'd0, 6, 1, 1, -1, -1, 0, 0);
    endtask

    task automatic t_max_width;      // R2 R4 full-scale width, zero gap
        load_counts(255, 0);
        run_burst("max width", 13'h1000, 8'h7E, 2'd1, 255, 1, 1, -1, -1, 0, 0);
    endtask

    initial begin
        #1500000;
        errors++;
        $display("FAIL R5 watchdog expired: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; tick = 1'b0; cfg_load = 1'b0; cfg_width = '0; cfg_gap = '0;
        start = 1'b0; start_addr = '0; start_data = '0; start_target = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_reset_counts();
        t_fast();
        t_slow_tick();
        t_zero_counts();
        t_start_busy();
        t_cfg_midburst();
        t_max_width();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule